// File: doc/BRIEF.md
# Write-Strobe Buffered Output Loader

This block keeps a small file of staged output words and one live output data register. Software loads the staged words over a simple register bus at any time, without disturbing the live output. A separate write-timing strobe then commits one staged word to the live output. The staged word is picked by a selector made of a bank bit and a three-bit slot address, which gives sixteen slots with the default parameters.

The strobe is asynchronous to the block clock. It is synchronized, and only its rising edge triggers a commit. Every commit sets a sticky event flag. Software clears the flag by writing a zero to it. When the interrupt enable bit is also set, the flag drives the interrupt output. When the flag is read as part of a read-modify-write sequence, it reads back as 1, so that writing the value back cannot clear an event that has not been serviced.

Top module: `strobe_buf_loader`

## Requirements
- R1: A rising edge on `wr_strobe` copies the selected slot into `out_data`. The new value appears after the third rising clock edge that follows the strobe going high (two synchronizer stages plus the output register). A falling edge copies nothing.
- R2: Slots are written at bus addresses 0 to 15, and the bus address is the slot index. Bus address 16 is the control word. The selector index is {bank, slot}, where bank is control bit 2 and slot is control bits 5:3.
- R3: Every commit sets the event flag (control bit 0). The flag never becomes 1 without a commit.
- R4: `irq` is 1 exactly while the event flag and the interrupt enable (control bit 1) are both 1. It updates on the same clock edge as they do.
- R5: A control write with bit 0 = 0 clears the event flag. A control write with bit 0 = 1 leaves the flag unchanged.
- R6: Read data appears on `bus_rdata` one clock after `bus_re`. A control read with `bus_rmw` = 1 returns bit 0 as 1. Without `bus_rmw`, bit 0 returns the true flag. Unused control bits read as 0.
- R7: A strobe held high for many cycles causes exactly one commit. Slot writes made while it stays high do not reach `out_data`.
- R8: When a flag-clearing control write lands on the same clock edge as a commit, the flag ends up 1.
- R9: Slot writes never change `out_data` outside a commit. A write to the selected slot on the same edge as a commit leaves `out_data` holding the slot's previous contents.
- R10: After a synchronous reset, `out_data`, the flag, the enable, the selector and `irq` are all 0.
- R11: A selector change written on the same edge as a commit takes effect only for later commits. That commit uses the previous selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read enable |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write |
| bus_addr | input | 5 | Register address: slots 0-15, control word 16 |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| wr_strobe | input | 1 | Asynchronous write-timing strobe |
| out_data | output | 8 | Live output data register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are collisions, where a bus write lands on exactly the clock edge that performs a commit. Such a write can target the selected slot, clear the flag, or move the selector. The bench reaches each collision by counting the synchronizer latency from the strobe edge and placing the bus write two cycles after the strobe rises. Random buffer writes, control writes, strobes of random width and read-modify-write reads are mixed between these collisions.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  // Control word bit positions; software and the bench depend on them.
  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_BANK_BIT = 2;
  localparam int CTRL_SEL_LSB  = 3;
endpackage

// File: rtl/wsl_strobe_edge.sv
module wsl_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= strobe_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/wsl_buf_file.sv
module wsl_buf_file #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/wsl_ctrl.sv
module wsl_ctrl
  import wsl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer,
  output logic              flag_o,
  output logic              ie_o,
  output logic [IDX_W-1:0]  sel_o,
  output logic              irq_o
);
  localparam int SEL_W = IDX_W - 1;

  logic             flag_q, ie_q, irq_q;
  logic [IDX_W-1:0] sel_q;
  logic             flag_d, ie_d;
  logic [IDX_W-1:0] sel_d;

  always_comb begin
    flag_d = flag_q;
    if (wr_en && !wdata[CTRL_FLAG_BIT]) flag_d = 1'b0;
    if (xfer) flag_d = 1'b1;           // set beats clear
    ie_d  = wr_en ? wdata[CTRL_IE_BIT] : ie_q;
    sel_d = wr_en ? {wdata[CTRL_BANK_BIT], wdata[CTRL_SEL_LSB +: SEL_W]} : sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      sel_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      sel_q  <= sel_d;
      irq_q  <= flag_d & ie_d;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign sel_o  = sel_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/strobe_buf_loader.sv
module strobe_buf_loader
  import wsl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = SEL_W + 1,
  localparam int NUM_BUF    = 1 << IDX_W,
  localparam int BUS_AW     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_rmw,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wr_strobe,
  output logic [DATA_W-1:0] out_data,
  output logic              irq
);
  localparam logic [BUS_AW-1:0] CTRL_ADDR = BUS_AW'(NUM_BUF);

  logic              xfer;
  logic              buf_we, ctrl_we;
  logic              flag_q, ie_q;
  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] sel_word, bus_word, ctrl_view;
  logic [DATA_W-1:0] out_q, rdata_q;

  assign buf_we  = bus_we && !bus_addr[BUS_AW-1];
  assign ctrl_we = bus_we && (bus_addr == CTRL_ADDR);

  wsl_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) strobe_i (
    .clk(clk), .rst(rst), .strobe_i(wr_strobe), .rise_o(xfer)
  );

  wsl_buf_file #(.DATA_W(DATA_W), .IDX_W(IDX_W)) bufs_i (
    .clk(clk), .we(buf_we), .waddr(bus_addr[IDX_W-1:0]), .wdata(bus_wdata),
    .raddr_a(sel_q), .rdata_a(sel_word),
    .raddr_b(bus_addr[IDX_W-1:0]), .rdata_b(bus_word)
  );

  wsl_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(ctrl_we), .wdata(bus_wdata), .xfer(xfer),
    .flag_o(flag_q), .ie_o(ie_q), .sel_o(sel_q), .irq_o(irq)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_FLAG_BIT] = flag_q | bus_rmw;
    ctrl_view[CTRL_IE_BIT]   = ie_q;
    ctrl_view[CTRL_BANK_BIT] = sel_q[IDX_W-1];
    ctrl_view[CTRL_SEL_LSB +: SEL_W] = sel_q[SEL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (xfer) out_q <= sel_word;   // slot read sees pre-write contents
      if (bus_re) begin
        if (!bus_addr[BUS_AW-1])       rdata_q <= bus_word;
        else if (bus_addr == CTRL_ADDR) rdata_q <= ctrl_view;
        else                            rdata_q <= '0;
      end
    end
  end

  assign out_data  = out_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/wsl_checker.sv
module wsl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer,
  input logic              flag,
  input logic              ie,
  input logic              irq,
  input logic              ctrl_we,
  input logic              ctrl_wbit0,
  input logic [DATA_W-1:0] dout
);
  a_r3_xfer_sets_flag: assert property (@(posedge clk) disable iff (rst)
    xfer |=> flag);
  a_r3_no_spurious_flag: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> !$rose(flag));
  a_r4_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie));
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !ctrl_wbit0 && !xfer) |=> !flag);
  a_r5_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wbit0 && flag) |=> flag);
  a_r7_single_commit: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);
  a_r9_dout_stable: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(dout));
endmodule

bind strobe_buf_loader wsl_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .xfer(xfer), .flag(flag_q), .ie(ie_q), .irq(irq),
  .ctrl_we(ctrl_we), .ctrl_wbit0(bus_wdata[wsl_pkg::CTRL_FLAG_BIT]),
  .dout(out_data)
);

// File: tb/strobe_buf_loader_tb_top.sv
module strobe_buf_loader_tb_top;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam logic [AW-1:0] CTRL = 5'd16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 0, bus_re = 0, bus_rmw = 0, wr_strobe = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, out_data;
  logic irq;

  always #10 clk = ~clk;   // 50 MHz

  strobe_buf_loader dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_strobe(wr_strobe), .out_data(out_data), .irq(irq)
  );

  // reference model
  logic [DW-1:0] m_buf [16];
  logic          m_flag, m_ie;
  logic [3:0]    m_sel;
  logic [DW-1:0] m_dout;

  int vec = 0, bad = 0;
  bit done = 0;

  function automatic logic [DW-1:0] exp_ctrl(input logic rmw);
    logic [DW-1:0] v = '0;
    v[0] = m_flag | rmw;
    v[1] = m_ie;
    v[2] = m_sel[3];
    v[5:3] = m_sel[2:0];
    return v;
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                      input bit in_commit);
    if (!a[4]) m_buf[a[3:0]] = d;
    else if (a == CTRL) begin
      m_ie  = d[1];
      m_sel = {d[2], d[5:3]};
      if (!d[0] && !in_commit) m_flag = 1'b0;
    end
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " out_data"}, out_data, m_dout);
    check({req, " irq"}, {7'd0, irq}, {7'd0, m_flag & m_ie});
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
    model_write(a, d, 0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic rmw, output logic [DW-1:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a; bus_rmw = rmw;
    @(negedge clk); bus_re = 0; bus_rmw = 0;
    d = bus_rdata;
  endtask

  task automatic strobe_pulse(input int hold);
    @(negedge clk); wr_strobe = 1;
    repeat (hold) @(negedge clk);
    wr_strobe = 0;
    repeat (4) @(negedge clk);
    m_dout = m_buf[m_sel];
    m_flag = 1'b1;
  endtask

  // bus write placed on the commit edge (2 negedges after strobe rises)
  task automatic collide(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_strobe = 1;
    @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
    m_dout = m_buf[m_sel];
    model_write(a, d, 1);
    m_flag = 1'b1;
    @(negedge clk); wr_strobe = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd, old;
    logic [AW-1:0] a;
    int r;
    void'($urandom(32'd4242));
    m_flag = 0; m_ie = 0; m_sel = 0; m_dout = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check_outputs("R10");
    bus_read(CTRL, 0, rd);
    check("R10 ctrl", rd, 8'h00);

    // R2 fill every slot, read each back
    for (int i = 0; i < 16; i++) bus_write(5'(i), 8'(8'hA0 + i * 3));
    for (int i = 0; i < 16; i++) begin
      bus_read(5'(i), 0, rd);
      check("R2 slot readback", rd, m_buf[i]);
    end
    check_outputs("R9 fill no effect");

    // R1/R2/R3/R4: select bank 1 slot 5, enable irq
    bus_write(CTRL, {2'b00, 3'd5, 1'b1, 1'b1, 1'b0});
    check_outputs("R4 enable only");
    strobe_pulse(1);
    check_outputs("R1 R3 R4 commit");
    bus_read(CTRL, 0, rd);
    check("R3 flag read", rd, exp_ctrl(0));

    // R5 write 1 keeps, write 0 clears
    bus_write(CTRL, {2'b00, 3'd5, 1'b1, 1'b1, 1'b1});
    check_outputs("R5 write-1 keeps");
    bus_write(CTRL, {2'b00, 3'd5, 1'b1, 1'b1, 1'b0});
    check_outputs("R5 write-0 clears");
    // R6 rmw read returns 1 for the flag
    bus_read(CTRL, 1, rd);
    check("R6 rmw read", rd, exp_ctrl(1));
    bus_read(CTRL, 0, rd);
    check("R6 plain read", rd, exp_ctrl(0));

    // R7 long hold: only one commit, later slot writes do not reach out
    @(negedge clk); wr_strobe = 1;
    repeat (5) @(negedge clk);
    m_dout = m_buf[m_sel]; m_flag = 1;
    bus_write(5'(m_sel), 8'h5C);
    repeat (4) @(negedge clk);
    check_outputs("R7 held strobe");
    wr_strobe = 0;
    repeat (5) @(negedge clk);
    check_outputs("R7 falling edge");

    // R8 clear collides with commit
    collide(CTRL, {2'b00, m_sel[2:0], m_sel[3], 1'b1, 1'b0});
    check_outputs("R8 set wins");
    // R9 write to selected slot collides with commit
    old = m_buf[m_sel];
    collide(5'(m_sel), ~old);
    check_outputs("R9 pre-write value");
    check("R9 old value", out_data, old);
    // R11 selector change collides with commit
    old = m_buf[m_sel];
    collide(CTRL, {2'b00, 3'd2, 1'b0, 1'b1, 1'b1});
    check_outputs("R11 old selector");
    check("R11 old value", out_data, old);
    strobe_pulse(2);
    check_outputs("R11 new selector");

    // random mix
    for (int it = 0; it < 400; it++) begin
      r = $urandom % 11;
      case (r)
        0, 1, 2: begin
          bus_write(5'($urandom % 16), 8'($urandom));
          check_outputs("R9 random slot write");
        end
        3, 4: begin
          bus_write(CTRL, 8'($urandom) & 8'h3F);
          check_outputs("R5 random ctrl write");
        end
        5, 6: begin
          strobe_pulse(1 + $urandom % 6);
          check_outputs("R1 random commit");
        end
        7: begin
          a = 5'($urandom % 16);
          bus_read(a, 0, rd);
          check("R2 random slot read", rd, m_buf[a[3:0]]);
        end
        8: begin
          r = $urandom % 2;
          bus_read(CTRL, r[0], rd);
          check("R6 random ctrl read", rd, exp_ctrl(r[0]));
        end
        default: begin
          r = $urandom % 3;
          if (r == 0) collide(5'(m_sel), 8'($urandom));
          else if (r == 1) collide(5'($urandom % 16), 8'($urandom));
          else collide(CTRL, 8'($urandom) & 8'h3E);
          check_outputs("R8 R9 R11 random collision");
        end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule